// File: doc/BRIEF.md
# Per-core inter-processor interrupt register file

This block keeps the inter-processor interrupt state of a group of cores behind one 32-bit register port. Each core has a sticky pending word, an enable word, two write-only ports that set or clear pending bits, eight 32-bit mailbox words, and its own level interrupt line. The requester index on each access picks which core's registers are touched. Cores pass messages by writing mailbox words. They signal each other through a send command that turns a 5-bit vector into one pending bit in a target core.

The interrupt line is a stored level, and its raise and lower rules are not mirror images. A set-style event raises it when pending AND enable is nonzero. A clear event lowers it only when pending becomes zero while the enable word is nonzero. A write to the enable word never moves the line by itself. Software must follow this exact sequence to quiet a core.

Every access gets a response one cycle later. The response carries read data and a decode-error flag. The error flag is raised for a requester index outside the core array, and for a send whose target does not exist. Neither kind of access changes any state.

Top module: `ipi_regfile`

## Requirements
- R1: After reset every pending word, enable word and mailbox word reads as zero, and every interrupt line is low.
- R2: Offset 0x04 is the enable word and reads back what was last written to it. Offset 0x00 returns the pending word, and writes to 0x00 change nothing.
- R3: A write to offset 0x08 ORs the write data into the pending word. If the pending word AND the enable word is nonzero afterwards, the core's interrupt line goes high, even when the write data is zero. Reads of 0x08 and 0x0C return zero.
- R4: A write to offset 0x0C clears the pending bits that are 1 in the write data. The interrupt line goes low only if the pending word is then zero and the enable word is nonzero. Otherwise the line keeps its value, including when the pending word reaches zero while the enable word is zero.
- R5: A write to the enable word leaves the interrupt line unchanged, whether it enables a pending bit or disables all bits.
- R6: Offsets 0x20 to 0x3C hold eight mailbox words, with word index (offset - 0x20) / 4. Each core has its own mailbox words.
- R7: A write to offset 0x40 is a send command. Bits 25:16 give the target core index and bits 4:0 give the vector. The command sets pending bit [vector] of the target core and applies the R3 raise rule to that core. The requester's own state is not changed.
- R8: A send whose target index is at or above the core count gets a decode error, and no core's state changes.
- R9: A read or write from a requester index at or above the core count gets a decode error and read data zero, and no core's state changes.
- R10: Reads of offsets that are not mapped, including 0x40, return zero without error. Writes to offsets that are not mapped change nothing.
- R11: Each access gets exactly one response, flagged by rsp_valid one cycle after the access. The read data is zero for writes and for errored accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_rid | input | RID_W | Requester core index |
| bus_off | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Decode error for that access |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |
| irq | output | NCORES | Per-core level interrupt |

## Verification
The hardest states to reach are the ones where the interrupt line and the pending word disagree. In one, the line stays high with nothing pending because the last clear happened while the enable word was zero. In the other, a bit is pending and enabled while the line is low, because enabling does not raise the line. The stimulus reaches both by ordering writes on one core. It clears pending bits with enable at zero, then re-enables and clears with zero data to lower the line. It also sets a bit with enable at zero, enables it, and raises the line with a zero-data set. Send commands then hit a core whose enable has only the top bit set, and out-of-range targets and requesters are interleaved with readbacks of every core.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int REG_W       = 32;
  localparam int OFF_W       = 8;
  localparam int MBOX_WORDS  = 8;
  localparam int MBOX_IDX_W  = $clog2(MBOX_WORDS);
  localparam int SEND_ID_LSB = 16;
  localparam int SEND_ID_W   = 10;
  localparam int VEC_W       = 5;

  localparam logic [OFF_W-1:0] OFF_PEND    = 8'h00;
  localparam logic [OFF_W-1:0] OFF_ENABLE  = 8'h04;
  localparam logic [OFF_W-1:0] OFF_SETP    = 8'h08;
  localparam logic [OFF_W-1:0] OFF_CLRP    = 8'h0C;
  localparam logic [OFF_W-1:0] OFF_MBOX_LO = 8'h20;
  localparam logic [OFF_W-1:0] OFF_MBOX_HI = 8'h3C;
  localparam logic [OFF_W-1:0] OFF_SEND    = 8'h40;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_PEND,
    KIND_ENABLE,
    KIND_SETP,
    KIND_CLRP,
    KIND_MBOX,
    KIND_SEND
  } reg_kind_e;

  typedef struct packed {
    logic                  set_stb;
    logic [REG_W-1:0]      set_val;
    logic                  clr_stb;
    logic                  en_wr;
    logic                  mb_wr;
    logic [MBOX_IDX_W-1:0] mb_idx;
    logic [REG_W-1:0]      wdata;
  } core_cmd_t;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int RID_W  = 4,
  localparam int CIDX_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [RID_W-1:0]      bus_rid,
  input  logic [OFF_W-1:0]      bus_off,
  input  logic [SEND_ID_W-1:0]  send_tgt,
  output reg_kind_e             kind,
  output logic [MBOX_IDX_W-1:0] mb_idx,
  output logic                  rid_ok,
  output logic                  tgt_ok,
  output logic [CIDX_W-1:0]     rid_idx,
  output logic [CIDX_W-1:0]     tgt_idx,
  output logic                  dec_err
);

  always_comb begin
    kind = KIND_NONE;
    if (bus_off == OFF_PEND)        kind = KIND_PEND;
    else if (bus_off == OFF_ENABLE) kind = KIND_ENABLE;
    else if (bus_off == OFF_SETP)   kind = KIND_SETP;
    else if (bus_off == OFF_CLRP)   kind = KIND_CLRP;
    else if (bus_off == OFF_SEND)   kind = KIND_SEND;
    else if (bus_off >= OFF_MBOX_LO && bus_off <= OFF_MBOX_HI) kind = KIND_MBOX;
  end

  assign mb_idx  = bus_off[MBOX_IDX_W+1:2];
  assign rid_ok  = (32'(bus_rid) < NCORES);
  assign tgt_ok  = (32'(send_tgt) < NCORES);
  assign rid_idx = bus_rid[CIDX_W-1:0];
  assign tgt_idx = send_tgt[CIDX_W-1:0];

  always_comb begin
    dec_err = 1'b0;
    if (bus_valid) begin
      if (!rid_ok)                                   dec_err = 1'b1;
      else if (bus_write && kind == KIND_SEND && !tgt_ok) dec_err = 1'b1;
    end
  end

endmodule

// File: rtl/ipi_core.sv
module ipi_core
  import ipi_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  core_cmd_t                              cmd,
  output logic [REG_W-1:0]                       pend_q,
  output logic [REG_W-1:0]                       en_q,
  output logic [MBOX_WORDS-1:0][REG_W-1:0]       mbox_q,
  output logic                                   irq_q
);

  logic [REG_W-1:0] pend_d;
  logic [REG_W-1:0] en_d;
  logic             irq_d;

  // pending word and interrupt level next state
  always_comb begin
    pend_d = pend_q;
    if (cmd.set_stb) pend_d = pend_q | cmd.set_val;
    else if (cmd.clr_stb) pend_d = pend_q & ~cmd.wdata;
  end

  always_comb begin
    irq_d = irq_q;
    if (cmd.set_stb && ((pend_d & en_q) != '0))
      irq_d = 1'b1;
    else if (cmd.clr_stb && (pend_d == '0) && (en_q != '0))
      irq_d = 1'b0;
  end

  assign en_d = cmd.en_wr ? cmd.wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  // mailbox words, one clock enable each
  for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_mbox
    logic word_we;
    assign word_we = cmd.mb_wr && (cmd.mb_idx == MBOX_IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mbox_q[w] <= '0;
      else if (word_we) mbox_q[w] <= cmd.wdata;
    end
  end

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(cmd.set_stb));

  // R4
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ($past(cmd.clr_stb) && (pend_q == '0) && (en_q != '0)));

  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmd.set_stb) && !$past(cmd.clr_stb)) |-> $stable(pend_q));

  // R5
  en_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd.en_wr) |-> $stable(irq_q));

endmodule

// File: rtl/ipi_rdmux.sv
module ipi_rdmux
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  localparam int CIDX_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic [NCORES-1:0][REG_W-1:0]                  pend_all,
  input  logic [NCORES-1:0][REG_W-1:0]                  en_all,
  input  logic [NCORES-1:0][MBOX_WORDS-1:0][REG_W-1:0]  mbox_all,
  input  logic [CIDX_W-1:0]                             sel,
  input  reg_kind_e                                     kind,
  input  logic [MBOX_IDX_W-1:0]                         mb_idx,
  output logic [REG_W-1:0]                              rdata
);

  logic [REG_W-1:0]                 sel_pend;
  logic [REG_W-1:0]                 sel_en;
  logic [MBOX_WORDS-1:0][REG_W-1:0] sel_mbox;

  always_comb begin
    sel_pend = '0;
    sel_en   = '0;
    sel_mbox = '0;
    for (int c = 0; c < NCORES; c++) begin
      if (sel == CIDX_W'(c)) begin
        sel_pend = pend_all[c];
        sel_en   = en_all[c];
        sel_mbox = mbox_all[c];
      end
    end
  end

  always_comb begin
    case (kind)
      KIND_PEND:   rdata = sel_pend;
      KIND_ENABLE: rdata = sel_en;
      KIND_MBOX:   rdata = sel_mbox[mb_idx];
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/ipi_regfile.sv
module ipi_regfile
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int RID_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [RID_W-1:0]     bus_rid,
  input  logic [7:0]           bus_off,
  input  logic [31:0]          bus_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  output logic [NCORES-1:0]    irq
);

  localparam int CIDX_W = (NCORES > 1) ? $clog2(NCORES) : 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  reg_kind_e             kind;
  logic [MBOX_IDX_W-1:0] mb_idx;
  logic                  rid_ok, tgt_ok, dec_err;
  logic [CIDX_W-1:0]     rid_idx, tgt_idx;

  ipi_decode #(.NCORES(NCORES), .RID_W(RID_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_rid   (bus_rid),
    .bus_off   (bus_off),
    .send_tgt  (bus_wdata[SEND_ID_LSB +: SEND_ID_W]),
    .kind      (kind),
    .mb_idx    (mb_idx),
    .rid_ok    (rid_ok),
    .tgt_ok    (tgt_ok),
    .rid_idx   (rid_idx),
    .tgt_idx   (tgt_idx),
    .dec_err   (dec_err)
  );

  logic             wr_ok;
  logic [REG_W-1:0] send_bit;
  assign wr_ok    = bus_valid && bus_write && !dec_err;
  assign send_bit = REG_W'(1) << bus_wdata[VEC_W-1:0];

  logic [NCORES-1:0][REG_W-1:0]                 pend_all;
  logic [NCORES-1:0][REG_W-1:0]                 en_all;
  logic [NCORES-1:0][MBOX_WORDS-1:0][REG_W-1:0] mbox_all;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    core_cmd_t cmd;
    logic      own;
    logic      hit_send;

    assign own      = wr_ok && rid_ok && (rid_idx == CIDX_W'(c));
    assign hit_send = wr_ok && (kind == KIND_SEND) && tgt_ok && (tgt_idx == CIDX_W'(c));

    always_comb begin
      cmd.set_stb = (own && kind == KIND_SETP) || hit_send;
      cmd.set_val = (kind == KIND_SEND) ? send_bit : bus_wdata;
      cmd.clr_stb = own && (kind == KIND_CLRP);
      cmd.en_wr   = own && (kind == KIND_ENABLE);
      cmd.mb_wr   = own && (kind == KIND_MBOX);
      cmd.mb_idx  = mb_idx;
      cmd.wdata   = bus_wdata;
    end

    ipi_core u_core (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cmd    (cmd),
      .pend_q (pend_all[c]),
      .en_q   (en_all[c]),
      .mbox_q (mbox_all[c]),
      .irq_q  (irq[c])
    );
  end

  logic [REG_W-1:0] rd_data;

  ipi_rdmux #(.NCORES(NCORES)) u_rdmux (
    .pend_all (pend_all),
    .en_all   (en_all),
    .mbox_all (mbox_all),
    .sel      (rid_idx),
    .kind     (kind),
    .mb_idx   (mb_idx),
    .rdata    (rd_data)
  );

  // response stage
  logic             rsp_valid_d, rsp_err_d;
  logic [REG_W-1:0] rsp_rdata_d;

  always_comb begin
    rsp_valid_d = bus_valid;
    rsp_err_d   = bus_valid && dec_err;
    rsp_rdata_d = (bus_valid && !bus_write && !dec_err) ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $past(bus_valid));

  // R9
  bad_rid_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && (32'(bus_rid) >= NCORES)) |=> (rsp_err && rsp_rdata == '0));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> ($past(irq) == irq));

endmodule

// File: tb/tb_ipi_regfile.sv
`timescale 1ns/1ps
module tb_ipi_regfile;

  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [3:0]  bus_rid;
  logic [7:0]  bus_off;
  logic [31:0] bus_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq;

  always #2.5 clk = ~clk;

  ipi_regfile #(.NCORES(NC), .RID_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_rid(bus_rid), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        err;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference state built from the requirements
  logic [31:0] m_pend [NC];
  logic [31:0] m_en   [NC];
  logic [31:0] m_mbox [NC][8];
  logic        m_irq  [NC];

  function automatic logic [31:0] m_read(int c, logic [7:0] off);
    if (off == 8'h00) return m_pend[c];
    if (off == 8'h04) return m_en[c];
    if (off >= 8'h20 && off <= 8'h3C) return m_mbox[c][(off - 8'h20) >> 2];
    return 32'h0;
  endfunction

  task automatic m_set(int c, logic [31:0] v);
    m_pend[c] = m_pend[c] | v;
    if ((m_pend[c] & m_en[c]) != 0) m_irq[c] = 1'b1;
  endtask

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response err=%0b rdata=%h expected none", rsp_err, rsp_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_err !== e.err || rsp_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s err=%0b rdata=%h expected err=%0b rdata=%h",
                   e.tag, rsp_err, rsp_rdata, e.err, e.rd);
        end
      end
    end
  end

  task automatic acc(bit wr, int rid, logic [7:0] off, logic [31:0] d, string tag);
    exp_t e;
    bit   bad;
    int   tgt;
    bad = (rid >= NC);
    tgt = int'(d[25:16]);
    if (wr && !bad && off == 8'h40 && tgt >= NC) bad = 1'b1;
    e.err = bad;
    e.rd  = (!wr && !bad) ? m_read(rid, off) : 32'h0;
    e.tag = tag;
    if (wr && !bad) begin
      if (off == 8'h04) m_en[rid] = d;
      else if (off == 8'h08) m_set(rid, d);
      else if (off == 8'h0C) begin
        m_pend[rid] = m_pend[rid] & ~d;
        if (m_pend[rid] == 0 && m_en[rid] != 0) m_irq[rid] = 1'b0;
      end else if (off >= 8'h20 && off <= 8'h3C) m_mbox[rid][(off - 8'h20) >> 2] = d;
      else if (off == 8'h40) m_set(tgt, 32'h1 << d[4:0]);
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_rid = 4'(rid); bus_off = off; bus_wdata = d;
    sb.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 response missing, pending=%0d expected 0", sb.size());
      sb.delete();
    end
  endtask

  task automatic chk_irq(string tag);
    logic [NC-1:0] exp;
    for (int c = 0; c < NC; c++) exp[c] = m_irq[c];
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq=%b expected %b", tag, irq, exp);
    end
  endtask

  task automatic rd_all(string tag);
    for (int c = 0; c < NC; c++) begin
      acc(0, c, 8'h00, 0, tag);
      acc(0, c, 8'h04, 0, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      m_pend[c] = 0; m_en[c] = 0; m_irq[c] = 0;
      for (int w = 0; w < 8; w++) m_mbox[c][w] = 0;
    end
    rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_rid = 0; bus_off = 0; bus_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq("R1");
    rd_all("R1");
    acc(0, 2, 8'h3C, 0, "R1");

    // R2 enable readback, pending read-only
    acc(1, 1, 8'h04, 32'h0000_00F0, "R2");
    acc(0, 1, 8'h04, 0, "R2");
    acc(1, 1, 8'h00, 32'h0000_0005, "R2");
    acc(0, 1, 8'h00, 0, "R2");

    // R3 set without overlap, then with overlap
    acc(1, 1, 8'h08, 32'h0000_0003, "R3");
    chk_irq("R3");
    acc(0, 1, 8'h00, 0, "R3");
    acc(0, 1, 8'h08, 0, "R3");
    acc(0, 1, 8'h0C, 0, "R3");
    acc(1, 1, 8'h08, 32'h0000_0010, "R3");
    chk_irq("R3");

    // R4 clear leaving bits pending keeps irq high
    acc(1, 1, 8'h0C, 32'h0000_0010, "R4");
    chk_irq("R4");
    acc(0, 1, 8'h00, 0, "R4");
    // R5 disabling everything keeps irq
    acc(1, 1, 8'h04, 32'h0, "R5");
    chk_irq("R5");
    // R4 pending reaches zero with enable zero: irq stays
    acc(1, 1, 8'h0C, 32'h0000_0003, "R4");
    chk_irq("R4");
    acc(1, 1, 8'h04, 32'h0000_0001, "R5");
    chk_irq("R5");
    // R4 zero-data clear with enable nonzero lowers
    acc(1, 1, 8'h0C, 32'h0, "R4");
    chk_irq("R4");

    // R5 enabling a pending bit does not raise; R3 zero-data set raises
    acc(1, 2, 8'h08, 32'h0000_0008, "R3");
    chk_irq("R3");
    acc(1, 2, 8'h04, 32'h0000_0008, "R5");
    chk_irq("R5");
    acc(1, 2, 8'h08, 32'h0, "R3");
    chk_irq("R3");

    // R6 mailbox words
    for (int w = 0; w < 8; w++) acc(1, 0, 8'(8'h20 + 4*w), 32'hA500_0000 | w * 32'h0101, "R6");
    for (int w = 0; w < 8; w++) acc(0, 0, 8'(8'h20 + 4*w), 0, "R6");
    acc(0, 3, 8'h20, 0, "R6");
    acc(1, 3, 8'h3C, 32'hDEAD_BEEF, "R6");
    acc(0, 3, 8'h3C, 0, "R6");
    acc(0, 0, 8'h3C, 0, "R6");

    // R7 send commands
    acc(1, 3, 8'h04, 32'h8000_0000, "R7");
    acc(1, 0, 8'h40, (32'd3 << 16) | 32'd31, "R7");
    chk_irq("R7");
    acc(0, 3, 8'h00, 0, "R7");
    acc(1, 0, 8'h40, 32'hFC00_FFE5 & ~(32'h3FF << 16) | (32'd3 << 16), "R7");
    acc(0, 3, 8'h00, 0, "R7");
    acc(0, 0, 8'h00, 0, "R7");
    chk_irq("R7");

    // R8 send to missing core
    acc(1, 1, 8'h40, (32'd4 << 16) | 32'd2, "R8");
    acc(1, 2, 8'h40, (32'h3FF << 16) | 32'd0, "R8");
    chk_irq("R8");
    rd_all("R8");

    // R9 bad requester
    acc(0, 4, 8'h00, 0, "R9");
    acc(1, 4, 8'h04, 32'hFFFF_FFFF, "R9");
    acc(1, 15, 8'h08, 32'hFFFF_FFFF, "R9");
    acc(0, 15, 8'h20, 0, "R9");
    chk_irq("R9");
    rd_all("R9");

    // R10 unmapped offsets
    acc(0, 0, 8'h10, 0, "R10");
    acc(1, 0, 8'h14, 32'h1234_5678, "R10");
    acc(0, 0, 8'h14, 0, "R10");
    acc(0, 0, 8'h40, 0, "R10");
    acc(1, 0, 8'h44, 32'hFFFF_FFFF, "R10");
    acc(0, 0, 8'hFC, 0, "R10");
    rd_all("R10");
    chk_irq("R10");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule